// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block turns a fast source clock and a slower reference clock into up to three output clocks. A main stage divides the source clock by an even ratio 2·P, with P a 5-bit setting. Each output then picks its own post-division of that clock by 1, 2, 4 or 8. An output can instead take the reference clock directly, or the reference divided by two. All divided clocks have a 50% duty cycle. The post-dividers are taken from one shared counter that advances on each rising edge of the main divided clock, so outputs on different ratios stay phase-aligned.

A single multifunction pin has a role chosen by a 2-bit field. It can act as the third clock output, an output-enable input for the first two outputs, a power-down input, or a frequency-select input. In frequency-select mode the pin picks one of two stored settings (set A or set B). Each set holds a P value and the three output source codes. The pin level passes through a two-flop synchronizer that resets to high, matching a pulled-up, undriven pin. Any change to the active setting restarts the divider chain from a known low phase.

Top module: `pclk_out_div`

## Requirements
- R1: With source code 0 (/1), an output has a period of 2·P source cycles and is high for P of them, for every P from 1 to 31.
- R2: Source codes 1, 2 and 3 give periods of 4·P, 8·P and 16·P source cycles respectively, each with 50% duty cycle. Each output's code sits at bits [3i+2:3i] of the osel word.
- R3: Source code 4 passes the reference clock to the output. Code 5 gives the reference divided by two, toggling on every reference rising edge. Codes 6 and 7 hold the output low.
- R4: Role field encodings are 0 = third clock, 1 = output enable, 2 = power down, 3 = frequency select. In role 0, clk_oe[2] is 1 and the pin level has no effect. In any other role, clk_out[2] is low and clk_oe[2] is 0.
- R5: In role 1, a low pin level drives clk_oe[1:0] to 0 and a high level drives it to 2'b11. In every other role, clk_oe[1:0] is 2'b11.
- R6: In role 2, a low pin level drives every clk_out low and holds the divider counters cleared. A high level resumes normal operation.
- R7: In role 3, a high pin level selects set A and a low level selects set B. In every other role, set A is used.
- R8: P = 0 holds all divided outputs low.
- R9: While reset is high, all divided outputs are low. The synchronized pin level resets to high, which selects the default behaviour of each role.
- R10: After any change of the active setting, the divider restarts from a low phase. The first rising edge of an output with post-ratio N follows the change by max(1, N−1)·P source cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset |
| src_clk | input | 1 | Fast source clock feeding the main divider |
| ref_clk | input | 1 | Reference clock for the bypass paths |
| pin_role | input | 2 | Role of the multifunction pin |
| pin_in | input | 1 | Level seen on the multifunction pin (asynchronous) |
| pdiv_a | input | 5 | Main divider setting P, set A |
| osel_a | input | 9 | Three 3-bit output source codes, set A |
| pdiv_b | input | 5 | Main divider setting P, set B |
| osel_b | input | 9 | Three 3-bit output source codes, set B |
| clk_out | output | 3 | Output clocks; bit 2 is the pin's clock role |
| clk_oe | output | 3 | Drive enables; low means tristate |

## Verification
The hardest case to reach from the ports is the restart after a setting change. The phase at which the old divider stopped is hidden, so a plain period check cannot see whether the chain restarted cleanly. The bench therefore changes P on a known falling edge of the source clock for every step of a sweep over P and post-ratios. It counts the cycles to the first rising edge and compares that count with the value computed from P and N, before it measures the steady period and high time. The power-down and frequency-select paths are reached by toggling the pin, then waiting out the synchronizer before sampling.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

    localparam int NOUT = 3;
    localparam int PW   = 5;
    localparam int SW   = 3;
    localparam int QW   = 3;

    typedef enum logic [1:0] {
        ROLE_CLK2 = 2'd0,
        ROLE_OE   = 2'd1,
        ROLE_PD   = 2'd2,
        ROLE_FSEL = 2'd3
    } pin_role_e;

    typedef enum logic [SW-1:0] {
        SRC_D1   = 3'd0,
        SRC_D2   = 3'd1,
        SRC_D4   = 3'd2,
        SRC_D8   = 3'd3,
        SRC_REF  = 3'd4,
        SRC_REFH = 3'd5,
        SRC_OFF6 = 3'd6,
        SRC_OFF7 = 3'd7
    } out_src_e;

    typedef struct packed {
        logic [PW-1:0]      pdiv;
        logic [NOUT*SW-1:0] osel;
    } cfg_t;

    typedef struct packed {
        logic pd;
        logic oe_lo;
        logic alt;
    } pin_ctl_t;

    function automatic logic post_pick(input out_src_e sel, input logic base,
                                       input logic [QW-1:0] q, input logic r,
                                       input logic rh);
        logic v;
        case (sel)
            SRC_D1:   v = base;
            SRC_D2:   v = q[0];
            SRC_D4:   v = q[1];
            SRC_D8:   v = q[2];
            SRC_REF:  v = r;
            SRC_REFH: v = rh;
            default:  v = 1'b0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/pclk_pin_ctl.sv
module pclk_pin_ctl
    import pclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pin_role_e role,
    input  logic      pin_in,
    output pin_ctl_t  ctl
);

    logic [1:0] sync;

    always_ff @(posedge clk) begin
        if (rst) sync <= 2'b11;
        else     sync <= {sync[0], pin_in};
    end

    always_comb begin
        ctl.pd    = (role == ROLE_PD)   && !sync[1];
        ctl.oe_lo = (role == ROLE_OE)   && !sync[1];
        ctl.alt   = (role == ROLE_FSEL) && !sync[1];
    end

    // R4: the pin serves one role at a time
    p_one_role_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.pd, ctl.oe_lo, ctl.alt}));

endmodule

// File: rtl/pclk_main_div.sv
module pclk_main_div
    import pclk_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic          restart,
    input  logic [PW-1:0] pdiv,
    output logic          base,
    output logic [QW-1:0] post
);

    logic [PW-1:0] cnt;
    logic          phase;
    logic [QW-1:0] q;
    logic          last;

    assign last = (cnt == pdiv - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || hold || restart || pdiv == '0) begin
            cnt   <= '0;
            phase <= 1'b0;
            q     <= '0;
        end else if (last) begin
            cnt   <= '0;
            phase <= !phase;
            if (!phase) q <= q + 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign base = phase;
    assign post = q;

    p_zero_low_r8: assert property (@(posedge clk) disable iff (rst)
        (pdiv == '0) |=> !phase);

    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
        (pdiv != '0 && pdiv == $past(pdiv)) |-> (cnt < pdiv));

    p_hold_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        hold |=> (cnt == '0 && !phase && q == '0));

    p_post_step_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(q) |-> ($rose(phase) || q == '0));

endmodule

// File: rtl/pclk_ref_div.sv
module pclk_ref_div (
    input  logic ref_clk,
    input  logic rst,
    output logic half
);

    always_ff @(posedge ref_clk) begin
        if (rst) half <= 1'b0;
        else     half <= !half;
    end

    p_half_toggle_r3: assert property (@(posedge ref_clk) disable iff (rst)
        !rst |=> (half != $past(half)));

endmodule

// File: rtl/pclk_out_div.sv
module pclk_out_div
    import pclk_pkg::*;
(
    input  logic                rst,
    input  logic                src_clk,
    input  logic                ref_clk,
    input  logic [1:0]          pin_role,
    input  logic                pin_in,
    input  logic [PW-1:0]       pdiv_a,
    input  logic [NOUT*SW-1:0]  osel_a,
    input  logic [PW-1:0]       pdiv_b,
    input  logic [NOUT*SW-1:0]  osel_b,
    output logic [NOUT-1:0]     clk_out,
    output logic [NOUT-1:0]     clk_oe
);

    pin_role_e     role;
    pin_ctl_t      ctl;
    cfg_t          cur;
    cfg_t          cfg_q;
    logic          restart;
    logic          base;
    logic [QW-1:0] post;
    logic          ref_half;

    assign role = pin_role_e'(pin_role);

    pclk_pin_ctl u_pin (
        .clk    (src_clk),
        .rst    (rst),
        .role   (role),
        .pin_in (pin_in),
        .ctl    (ctl)
    );

    always_comb begin
        if (ctl.alt) begin
            cur.pdiv = pdiv_b;
            cur.osel = osel_b;
        end else begin
            cur.pdiv = pdiv_a;
            cur.osel = osel_a;
        end
    end

    always_ff @(posedge src_clk) begin
        cfg_q <= cur;
    end

    assign restart = (cur != cfg_q);

    pclk_main_div u_main (
        .clk     (src_clk),
        .rst     (rst),
        .hold    (ctl.pd),
        .restart (restart),
        .pdiv    (cur.pdiv),
        .base    (base),
        .post    (post)
    );

    pclk_ref_div u_ref (
        .ref_clk (ref_clk),
        .rst     (rst),
        .half    (ref_half)
    );

    for (genvar i = 0; i < NOUT; i++) begin : g_out
        logic raw;
        assign raw = post_pick(out_src_e'(cur.osel[i*SW +: SW]), base, post,
                               ref_clk, ref_half);
        if (i == NOUT - 1) begin : g_pin_clk
            assign clk_out[i] = (role == ROLE_CLK2) && !ctl.pd && raw;
            assign clk_oe[i]  = (role == ROLE_CLK2);
        end else begin : g_fixed_clk
            assign clk_out[i] = !ctl.pd && raw;
            assign clk_oe[i]  = !ctl.oe_lo;
        end
    end

endmodule

// File: tb/sim_pclk_out_div.sv
module sim_pclk_out_div;

    logic       rst = 1'b1;
    logic       src_clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic [1:0] pin_role = 2'd0;
    logic       pin_in = 1'b1;
    logic [4:0] pdiv_a = 5'd1;
    logic [8:0] osel_a = 9'd0;
    logic [4:0] pdiv_b = 5'd1;
    logic [8:0] osel_b = 9'd0;
    logic [2:0] clk_out;
    logic [2:0] clk_oe;

    int total = 0;
    int fails = 0;

    always #2.5 src_clk = ~src_clk;
    always #7   ref_clk = ~ref_clk;

    pclk_out_div u0 (
        .rst(rst), .src_clk(src_clk), .ref_clk(ref_clk),
        .pin_role(pin_role), .pin_in(pin_in),
        .pdiv_a(pdiv_a), .osel_a(osel_a), .pdiv_b(pdiv_b), .osel_b(osel_b),
        .clk_out(clk_out), .clk_oe(clk_oe)
    );

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    function automatic logic [8:0] pack(input int c0, input int c1, input int c2);
        return {3'(c2), 3'(c1), 3'(c0)};
    endfunction

    task automatic meas(input int i, output int hi, output int lo);
        int g;
        hi = 0; lo = 0; g = 0;
        @(negedge src_clk);
        while (clk_out[i] && g < 4000) begin @(negedge src_clk); g++; end
        while (!clk_out[i] && g < 4000) begin @(negedge src_clk); g++; end
        while (clk_out[i] && g < 4000) begin hi++; @(negedge src_clk); g++; end
        while (!clk_out[i] && g < 4000) begin lo++; @(negedge src_clk); g++; end
    endtask

    task automatic low_for(input int i, input int n, input string req);
        int seen;
        seen = 0;
        repeat (n) begin
            @(negedge src_clk);
            if (clk_out[i]) seen++;
        end
        chk(seen == 0, req, seen, 0);
    endtask

    initial begin
        repeat (190000) @(posedge src_clk);
        total++; fails++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int hi, lo, k, n, code, p;
        int plist [7] = '{1, 2, 3, 5, 8, 17, 31};

        // R9: outputs low while reset is held
        osel_a = pack(0, 1, 3);
        repeat (6) @(negedge src_clk);
        chk(clk_out == 3'b000, "R9", int'(clk_out), 0);
        chk(clk_oe == 3'b111, "R4", int'(clk_oe), 7);
        repeat (6) @(negedge src_clk);
        rst = 1'b0;
        repeat (4) @(negedge src_clk);

        // R1 R2 R10: sweep P and post ratios
        foreach (plist[j]) begin
            p = plist[j];
            pdiv_a = 5'(p);
            osel_a = pack(j % 4, (j + 1) % 4, (j + 2) % 4);
            n = 1 << (j % 4);
            k = 0;
            do begin @(negedge src_clk); k++; end while (!clk_out[0] && k < 3000);
            chk(k == ((n == 1) ? 1 : n - 1) * p + 1, "R10", k, ((n == 1) ? 1 : n - 1) * p + 1);
            for (int i = 0; i < 3; i++) begin
                code = (j + i) % 4;
                n = 1 << code;
                meas(i, hi, lo);
                chk(hi == p * n && lo == p * n, (code == 0) ? "R1" : "R2", hi + lo, 2 * p * n);
            end
        end

        // R8: P of zero keeps outputs low
        pdiv_a = 5'd0;
        osel_a = pack(0, 1, 3);
        low_for(0, 200, "R8");
        low_for(2, 50, "R8");

        // R3: reference bypass paths and unused codes
        pdiv_a = 5'd3;
        osel_a = pack(4, 5, 6);
        repeat (4) @(negedge src_clk);
        for (int t = 0; t < 4; t++) begin
            @(posedge ref_clk); #3;
            chk(clk_out[0] == 1'b1, "R3", int'(clk_out[0]), 1);
            @(negedge ref_clk); #3;
            chk(clk_out[0] == 1'b0, "R3", int'(clk_out[0]), 0);
        end
        @(negedge ref_clk);
        for (int t = 0; t < 6; t++) begin
            logic v;
            v = clk_out[1];
            @(negedge ref_clk);
            chk(clk_out[1] == !v, "R3", int'(clk_out[1]), int'(!v));
        end
        low_for(2, 60, "R3");

        // R4: clock role ignores the pin level
        osel_a = pack(0, 0, 0);
        pin_in = 1'b0;
        repeat (5) @(negedge src_clk);
        chk(clk_oe == 3'b111, "R4", int'(clk_oe), 7);
        meas(2, hi, lo);
        chk(hi == 3 && lo == 3, "R4", hi + lo, 6);

        // R5: output enable role
        pin_role = 2'd1;
        repeat (5) @(negedge src_clk);
        chk(clk_oe == 3'b000, "R5", int'(clk_oe), 0);
        low_for(2, 40, "R4");
        pin_in = 1'b1;
        repeat (5) @(negedge src_clk);
        chk(clk_oe == 3'b011, "R5", int'(clk_oe), 3);
        meas(0, hi, lo);
        chk(hi == 3 && lo == 3, "R5", hi + lo, 6);

        // R6: power down role
        pin_role = 2'd2;
        osel_a = pack(0, 4, 0);
        repeat (5) @(negedge src_clk);
        chk(clk_oe == 3'b011, "R5", int'(clk_oe), 3);
        pin_in = 1'b0;
        repeat (4) @(negedge src_clk);
        low_for(0, 100, "R6");
        low_for(1, 100, "R6");
        pin_in = 1'b1;
        repeat (4) @(negedge src_clk);
        meas(0, hi, lo);
        chk(hi == 3 && lo == 3, "R6", hi + lo, 6);

        // R7: frequency select role
        pin_role = 2'd3;
        pdiv_a = 5'd2; osel_a = pack(0, 0, 0);
        pdiv_b = 5'd5; osel_b = pack(1, 0, 0);
        repeat (5) @(negedge src_clk);
        meas(0, hi, lo);
        chk(hi == 2 && lo == 2, "R7", hi + lo, 4);
        pin_in = 1'b0;
        repeat (5) @(negedge src_clk);
        meas(0, hi, lo);
        chk(hi == 10 && lo == 10, "R7", hi + lo, 20);
        pin_role = 2'd1;
        repeat (5) @(negedge src_clk);
        meas(0, hi, lo);
        chk(hi == 2 && lo == 2, "R7", hi + lo, 4);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule